// File: doc/BRIEF.md
# Paged IOMMU Translation Lookup

This block turns a device bus address into a physical page base by indexing a table of 64-bit page entries. Every entry holds a page base in its upper bits and a two-bit access code in its lowest two bits. The page size is 2 to the power of a runtime shift that arrives with each request. The block returns four values: the page-aligned request address, the translated page base, the mask of in-page offset bits, and the access code. A bypass flag makes it grant full access without reading the table.

An update engine outside this block loads entries through a simple write port. The table sits in a synchronous RAM. After every reset a small state machine walks that RAM and writes zero to each entry. It has two states. ST_CLEAR sweeps the RAM one entry per cycle, holds `req_ready` low and drops writes from the external port. ST_RUN accepts lookups. The only transition, SWEEP_DONE, goes from ST_CLEAR to ST_RUN on the cycle that clears the last entry. Reset always returns the machine to ST_CLEAR.

Requests use a valid/ready handshake. The response appears exactly one cycle after a request is accepted, and a new request may be accepted on every cycle.

Top module: `iommu_page_xlate`

## Requirements
- R1: After reset is released, `req_ready` stays low for exactly DEPTH clock cycles and then stays high until the next reset.
- R2: After the clearing sweep, every entry reads as zero: an in-range lookup returns access code 0, a zero translated base and a nonzero iova only from the address itself.
- R3: For an in-range lookup with page mask PM = ~(2^shift - 1), the response is iova = addr & PM, phys = entry & PM, mask = ~PM and perm = entry[1:0]. The perm encoding is 0 = no access, 1 = read only, 2 = write only, 3 = read and write.
- R4: The table index is `req_addr >> req_shift`, taken with the shift given in the same request, so one address selects different entries under different shifts.
- R5: A lookup whose index is at or beyond DEPTH returns perm 0, iova 0, phys 0 and an all-ones mask.
- R6: While bypass is on, every lookup, in range or not, returns perm 3, iova 0, phys 0 and an all-ones mask. `byp_we` loads `byp_val` into the bypass flag at the clock edge, and requests accepted after that edge see the new value.
- R7: `resp_valid` is high in the cycle right after each accepted request (`req_valid && req_ready`) and low otherwise, even when requests come back to back. While it is low, all response fields are zero.
- R8: When a table write and an accepted lookup address the same entry at the same edge, the lookup returns the entry's previous contents, and a later lookup returns the new contents.
- R9: Table writes presented while `req_ready` is low are dropped.
- R10: Reset turns bypass off, and entries written before a reset read as zero after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the clearing sweep |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a lookup (high in ST_RUN) |
| req_addr | input | ADDR_W | Bus address to translate |
| req_shift | input | SHIFT_W | Page-size shift for this request |
| byp_we | input | 1 | Load the bypass flag |
| byp_val | input | 1 | New bypass flag value |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | IDX_W | Table write index |
| tbl_data | input | ADDR_W | Entry to write (page base and access code) |
| resp_valid | output | 1 | Response valid, one cycle after acceptance |
| resp_iova | output | ADDR_W | Page-aligned request address |
| resp_phys | output | ADDR_W | Translated page base |
| resp_mask | output | ADDR_W | In-page offset mask |
| resp_perm | output | 2 | Access code |

## Verification
Two cases are the hardest to reach from the ports. The first is the window in which the clearing sweep has already passed an entry but has not yet finished. To reach it, the bench drives a write to entry 0 partway through the sweep and later reads that entry to show that the write was dropped. The second is a read and a write to the same entry at the same edge. The bench lines up a write and a lookup to one index in the same cycle, then issues a second lookup to the same index, to tell old contents from new. The main table walk issues its requests back to back, so the one-cycle pipeline is exercised continuously, with shifts of 0 and 63 at the two ends of the range.

// File: rtl/iommu_xlate_pkg.sv
package iommu_xlate_pkg;

    typedef enum logic [0:0] {
        ST_CLEAR = 1'b0,
        ST_RUN   = 1'b1
    } ixl_state_e;

    typedef enum logic [1:0] {
        PERM_NONE = 2'd0,
        PERM_RD   = 2'd1,
        PERM_WR   = 2'd2,
        PERM_RW   = 2'd3
    } ixl_perm_e;

endpackage

// File: rtl/ixl_entry_ram.sv
module ixl_entry_ram #(
    parameter int DEPTH = 64,
    parameter int W     = 64,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [W-1:0]     wdata,
    input  logic             re,
    input  logic [IDX_W-1:0] ridx,
    output logic [W-1:0]     rdata
);
    logic [W-1:0] mem [DEPTH];

    // read-first: a same-edge write to ridx is not visible in rdata
    always_ff @(posedge clk) begin
        if (re) begin
            rdata <= mem[ridx];
        end
        if (we) begin
            mem[widx] <= wdata;
        end
    end
endmodule

// File: rtl/ixl_clear_ctl.sv
module ixl_clear_ctl
    import iommu_xlate_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    output logic             run,
    output logic             clr_we,
    output logic [IDX_W-1:0] clr_idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    ixl_state_e state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_CLEAR: begin
                if (idx_q == LAST) begin
                    state_d = ST_RUN;
                    idx_d   = '0;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            ST_RUN: begin
                state_d = ST_RUN;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_CLEAR;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        run     = 1'b0;
        clr_we  = 1'b0;
        clr_idx = idx_q;
        unique case (state_q)
            ST_CLEAR: clr_we = 1'b1;
            ST_RUN:   run    = 1'b1;
        endcase
    end
endmodule

// File: rtl/ixl_resp_fmt.sv
module ixl_resp_fmt
    import iommu_xlate_pkg::*;
#(
    parameter int ADDR_W = 64,
    localparam int SHIFT_W = $clog2(ADDR_W)
) (
    input  logic               valid,
    input  logic               bypass,
    input  logic               inrange,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [SHIFT_W-1:0] shift,
    input  logic [ADDR_W-1:0]  entry,
    output logic [ADDR_W-1:0]  iova,
    output logic [ADDR_W-1:0]  phys,
    output logic [ADDR_W-1:0]  mask,
    output logic [1:0]         perm
);
    logic [ADDR_W-1:0] page_mask;

    always_comb begin
        page_mask = ~((ADDR_W'(1) << shift) - ADDR_W'(1));
        iova = '0;
        phys = '0;
        mask = '0;
        perm = PERM_NONE;
        if (valid) begin
            if (bypass) begin
                mask = '1;
                perm = PERM_RW;
            end else if (!inrange) begin
                mask = '1;
                perm = PERM_NONE;
            end else begin
                iova = addr & page_mask;
                phys = entry & page_mask;
                mask = ~page_mask;
                perm = entry[1:0];
            end
        end
    end
endmodule

// File: rtl/iommu_page_xlate.sv
module iommu_page_xlate
    import iommu_xlate_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DEPTH  = 64,
    localparam int SHIFT_W = $clog2(ADDR_W),
    localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [SHIFT_W-1:0] req_shift,
    input  logic               byp_we,
    input  logic               byp_val,
    input  logic               tbl_we,
    input  logic [IDX_W-1:0]   tbl_idx,
    input  logic [ADDR_W-1:0]  tbl_data,
    output logic               resp_valid,
    output logic [ADDR_W-1:0]  resp_iova,
    output logic [ADDR_W-1:0]  resp_phys,
    output logic [ADDR_W-1:0]  resp_mask,
    output logic [1:0]         resp_perm
);
    logic               run;
    logic               clr_we;
    logic [IDX_W-1:0]   clr_idx;
    logic               fire;
    logic [ADDR_W-1:0]  idx_full;
    logic               inrange;
    logic               ram_we;
    logic [IDX_W-1:0]   ram_widx;
    logic [ADDR_W-1:0]  ram_wdata;
    logic [ADDR_W-1:0]  ram_rdata;
    logic               bypass_q;
    logic               s1_valid;
    logic               s1_bypass;
    logic               s1_inrange;
    logic [ADDR_W-1:0]  s1_addr;
    logic [SHIFT_W-1:0] s1_shift;

    ixl_clear_ctl #(.DEPTH(DEPTH)) u_clr (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .clr_we  (clr_we),
        .clr_idx (clr_idx)
    );

    assign req_ready = run;
    assign fire      = req_valid && run;
    assign idx_full  = req_addr >> req_shift;
    assign inrange   = idx_full < ADDR_W'(DEPTH);

    // clearing sweep owns the write port; external writes need ST_RUN
    assign ram_we    = clr_we || (tbl_we && run);
    assign ram_widx  = clr_we ? clr_idx : tbl_idx;
    assign ram_wdata = clr_we ? '0 : tbl_data;

    ixl_entry_ram #(.DEPTH(DEPTH), .W(ADDR_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .widx  (ram_widx),
        .wdata (ram_wdata),
        .re    (fire),
        .ridx  (idx_full[IDX_W-1:0]),
        .rdata (ram_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bypass_q <= 1'b0;
        end else if (byp_we) begin
            bypass_q <= byp_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid   <= 1'b0;
            s1_bypass  <= 1'b0;
            s1_inrange <= 1'b0;
            s1_addr    <= '0;
            s1_shift   <= '0;
        end else begin
            s1_valid <= fire;
            if (fire) begin
                s1_bypass  <= bypass_q;
                s1_inrange <= inrange;
                s1_addr    <= req_addr;
                s1_shift   <= req_shift;
            end
        end
    end

    assign resp_valid = s1_valid;

    ixl_resp_fmt #(.ADDR_W(ADDR_W)) u_fmt (
        .valid   (s1_valid),
        .bypass  (s1_bypass),
        .inrange (s1_inrange),
        .addr    (s1_addr),
        .shift   (s1_shift),
        .entry   (ram_rdata),
        .iova    (resp_iova),
        .phys    (resp_phys),
        .mask    (resp_mask),
        .perm    (resp_perm)
    );
endmodule

// File: rtl/ixl_checker.sv
module ixl_checker #(
    parameter int ADDR_W = 64,
    parameter int DEPTH  = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              resp_valid,
    input logic [ADDR_W-1:0] resp_iova,
    input logic [ADDR_W-1:0] resp_phys,
    input logic [ADDR_W-1:0] resp_mask,
    input logic [1:0]        resp_perm
);
    localparam int CW = $clog2(DEPTH + 1) + 1;
    logic [CW-1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
        end else if (since_rst < CW'(DEPTH)) begin
            since_rst <= since_rst + 1'b1;
        end
    end

    a_r1_ready_after_sweep: assert property (@(posedge clk) disable iff (rst)
        req_ready == (since_rst == CW'(DEPTH)));

    a_r7_resp_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> resp_valid);

    a_r7_no_spurious_resp: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_ready) |=> !resp_valid);

    a_r7_idle_fields_zero: assert property (@(posedge clk) disable iff (rst)
        !resp_valid |-> (resp_perm == 2'd0 && resp_mask == '0 &&
                         resp_phys == '0 && resp_iova == '0));

    a_r5_full_mask_zero_base: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_mask == '1) |-> (resp_phys == '0 && resp_iova == '0));

    a_r3_bases_aligned: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> ((resp_iova & resp_mask) == '0 && (resp_phys & resp_mask) == '0));
endmodule

bind iommu_page_xlate ixl_checker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_iova  (resp_iova),
    .resp_phys  (resp_phys),
    .resp_mask  (resp_mask),
    .resp_perm  (resp_perm)
);

// File: tb/iommu_page_xlate_test.sv
module iommu_page_xlate_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 64;
    localparam int DP = 64;
    localparam int NV = 10;

    // {shift[5:0], addr[63:0]}
    localparam logic [69:0] VEC [NV] = '{
        {6'd12, 64'h0000_0000_0000_3ABC},
        {6'd12, 64'h0000_0000_0003_F123},
        {6'd12, 64'h0000_0000_0004_0000},
        {6'd16, 64'h0000_0000_0005_FFFF},
        {6'd0,  64'h0000_0000_0000_002A},
        {6'd20, 64'h0000_0000_00A0_0001},
        {6'd63, 64'h8000_0000_0000_0001},
        {6'd63, 64'h0000_0000_0000_1234},
        {6'd12, 64'hFFFF_FFFF_FFFF_F000},
        {6'd6,  64'h0000_0000_0000_0FC5}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [5:0]    req_shift = '0;
    logic          byp_we = 1'b0;
    logic          byp_val = 1'b0;
    logic          tbl_we = 1'b0;
    logic [5:0]    tbl_idx = '0;
    logic [AW-1:0] tbl_data = '0;
    logic          resp_valid;
    logic [AW-1:0] resp_iova, resp_phys, resp_mask;
    logic [1:0]    resp_perm;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;
    logic [AW-1:0] model [DP];

    always #(CLK_PERIOD/2) clk = ~clk;

    iommu_page_xlate uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_shift(req_shift), .byp_we(byp_we),
        .byp_val(byp_val), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
        .tbl_data(tbl_data), .resp_valid(resp_valid), .resp_iova(resp_iova),
        .resp_phys(resp_phys), .resp_mask(resp_mask), .resp_perm(resp_perm)
    );

    function automatic logic [AW-1:0] ent(int i);
        return {16'hC0DE, 16'(i), 20'h12345, 6'(i), 4'h0, 2'(i % 4)};
    endfunction

    task automatic expect_resp(input string tag, input bit byp,
                               input logic [5:0] sh, input logic [AW-1:0] a);
        logic [AW-1:0] pm, idx, e_iova, e_phys, e_mask;
        logic [1:0] e_perm;
        pm  = ~((64'd1 << sh) - 64'd1);
        idx = a >> sh;
        if (byp) begin
            e_iova = '0; e_phys = '0; e_mask = '1; e_perm = 2'd3;
        end else if (idx >= 64'(DP)) begin
            e_iova = '0; e_phys = '0; e_mask = '1; e_perm = 2'd0;
        end else begin
            e_iova = a & pm;
            e_phys = model[idx[5:0]] & pm;
            e_mask = ~pm;
            e_perm = model[idx[5:0]][1:0];
        end
        n_run++;
        if (resp_valid !== 1'b1 || resp_iova !== e_iova || resp_phys !== e_phys ||
            resp_mask !== e_mask || resp_perm !== e_perm) begin
            n_fail++;
            $display("FAIL %s: got v=%b iova=%h phys=%h mask=%h perm=%0d exp v=1 iova=%h phys=%h mask=%h perm=%0d",
                     tag, resp_valid, resp_iova, resp_phys, resp_mask, resp_perm,
                     e_iova, e_phys, e_mask, e_perm);
        end
    endtask

    task automatic check_bit(input string tag, input logic got, input logic exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b exp %b", tag, got, exp);
        end
    endtask

    task automatic wait_ready(output int cycles);
        cycles = 0;
        while (req_ready !== 1'b1 && cycles < 1000) begin
            @(negedge clk);
            cycles++;
        end
    endtask

    task automatic single_req(input string tag, input bit byp,
                              input logic [5:0] sh, input logic [AW-1:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_shift = sh; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        expect_resp(tag, byp, sh, a);
    endtask

    task automatic write_entry(input int i, input logic [AW-1:0] d);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = 6'(i); tbl_data = d;
        @(negedge clk);
        tbl_we = 1'b0;
        model[i] = d;
    endtask

    initial begin
        int cyc;
        for (int i = 0; i < DP; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: ready stays low during the sweep, resp_valid idle
        @(negedge clk);
        check_bit("R1 ready low in sweep", req_ready, 1'b0);
        check_bit("R7 resp idle in sweep", resp_valid, 1'b0);
        // R9: write to entry 0 after the sweep passed it must be dropped
        repeat (8) @(negedge clk);
        tbl_we = 1'b1; tbl_idx = 6'd0; tbl_data = 64'hDEAD_BEEF_0000_1003;
        @(negedge clk);
        tbl_we = 1'b0;
        wait_ready(cyc);
        // ready rose DP edges after release; 10 negedges already passed
        n_run++;
        if (cyc + 10 != DP) begin
            n_fail++;
            $display("FAIL R1 ready delay: got %0d exp %0d", cyc + 10, DP);
        end
        single_req("R9 write during sweep dropped", 0, 6'd12, 64'h0000_0000_0000_0010);
        single_req("R2 cleared entry 7", 0, 6'd12, 64'h0000_0000_0000_7FFF);

        for (int i = 0; i < DP; i++) write_entry(i, ent(i));

        // R3 R4 R5 R7: back-to-back walk of the vector table
        for (int i = 0; i <= NV; i++) begin
            @(negedge clk);
            if (i > 0) expect_resp($sformatf("R3/R4/R5 vec %0d", i - 1), 0,
                                   VEC[i-1][69:64], VEC[i-1][63:0]);
            if (i < NV) begin
                req_valid = 1'b1; req_shift = VEC[i][69:64]; req_addr = VEC[i][63:0];
            end else begin
                req_valid = 1'b0;
            end
        end
        @(negedge clk);
        check_bit("R7 valid drops after last", resp_valid, 1'b0);

        // R8: same-edge write and lookup to entry 3
        @(negedge clk);
        req_valid = 1'b1; req_shift = 6'd12; req_addr = 64'h3000;
        tbl_we = 1'b1; tbl_idx = 6'd3; tbl_data = 64'hAAAA_5555_0000_0002;
        @(negedge clk);
        req_valid = 1'b0; tbl_we = 1'b0;
        expect_resp("R8 old entry on collision", 0, 6'd12, 64'h3000);
        model[3] = 64'hAAAA_5555_0000_0002;
        single_req("R8 new entry afterwards", 0, 6'd12, 64'h3000);

        // R6: bypass on
        @(negedge clk);
        byp_we = 1'b1; byp_val = 1'b1;
        @(negedge clk);
        byp_we = 1'b0;
        single_req("R6 bypass in range", 1, 6'd12, 64'h5123);
        single_req("R6 bypass out of range", 1, 6'd12, 64'hFFFF_0000);
        @(negedge clk);
        byp_we = 1'b1; byp_val = 1'b0;
        @(negedge clk);
        byp_we = 1'b0;
        single_req("R6 bypass off", 0, 6'd12, 64'h5123);

        // R10: reset mid-operation clears table and bypass
        @(negedge clk);
        byp_we = 1'b1; byp_val = 1'b1;
        @(negedge clk);
        byp_we = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < DP; i++) model[i] = '0;
        wait_ready(cyc);
        check_bit("R1 ready after second sweep", req_ready, 1'b1);
        single_req("R10 entry 3 cleared, bypass off", 0, 6'd12, 64'h3ABC);
        single_req("R10 entry 63 cleared", 0, 6'd6, 64'hFC0);

        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule